// File: doc/BRIEF.md
# Switchable-Layout Cartridge Bank Translator

This block sits between a console CPU, a picture processor and cartridge memories. It turns their addresses into bank numbers. The CPU programs eight 8-bit bank values and one control byte through writes in 0x8000–0x9FFF. The control byte picks which bank value a data write lands in. It also holds two layout switches: one swaps the first and third 8 KB program slots, and the other swaps the two 4 KB halves of the pattern space.

For CPU accesses at 0x8000–0xFFFF, the block returns an 8 KB program bank index. For picture-processor accesses at 0x0000–0x1FFF, it returns a 1 KB page number and a flag. The flag says whether the page lives in pattern ROM or in an 8 KB pattern RAM, and it is taken from bit 6 of the page's bank value. The block also stores a nametable arrangement bit. It gates the work RAM at 0x6000–0x7FFF with an enable bit and a write-lock bit. All translation is combinational from the current register state, and register writes take effect at the next rising clock edge.

Top module: `bank_xlate`

## Requirements
- R1: With `cpu_wr` high at an even address in 0x8000–0x9FFF, the data byte is stored as the control byte. At an odd address in that range, the data byte is stored into bank value number (control & 7). Any address in the range decodes this way, including 0x9FFE and 0x9FFF.
- R2: With control bit 6 clear, the four 8 KB CPU slots starting at 0x8000 resolve to value 6, value 7, bank count−2 and bank count−1, in that order.
- R3: With control bit 6 set, the four slots resolve to bank count−2, value 7, value 6 and bank count−1, in that order.
- R4: A program bank taken from a bank value is that value modulo `PRG_BANKS`.
- R5: With control bit 7 clear, pattern pages 0 and 1 use value 0 with bit 0 forced to 0 and to 1 respectively. Pages 2 and 3 do the same with value 1. Pages 4 to 7 use values 2 to 5.
- R6: With control bit 7 set, the page layout is rotated by four, so page p takes what page (p+4) mod 8 takes when the bit is clear.
- R7: When bit 6 of the selected value is set, `chr_is_ram` is 1 and `chr_page` is value & 7. Otherwise `chr_is_ram` is 0 and `chr_page` is value & 0x3F.
- R8: `chr_ram_we` is high only when `ppu_wr` is high, `ppu_addr` is below 0x2000 and the addressed page maps to RAM. A write to a ROM page or above 0x1FFF produces no write strobe.
- R9: A write to an even address in 0xA000–0xBFFF sets `mirror_h` from data bit 0, where 0 means vertical and 1 means horizontal.
- R10: A write to an odd address in 0xA000–0xBFFF sets the work-RAM enable from data bit 7 and the write lock from data bit 6. `wram_rd_en` is high for addresses in 0x6000–0x7FFF while the RAM is enabled; when it is low, read data must be forced to 0. `wram_we` needs a write in that range with the RAM enabled and not locked.
- R11: After reset, all bank values and the control byte are 0, `mirror_h` is 0, the work RAM is enabled and it is not locked.
- R12: Writes outside 0x6000–0xBFFF leave every register unchanged. This includes writes at 0xC000–0xFFFF and 0x4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_wr | input | 1 | Picture-processor write strobe |
| prg_bank | output | $clog2(PRG_BANKS) | 8 KB program bank for `cpu_addr` |
| chr_is_ram | output | 1 | Addressed pattern page lives in pattern RAM |
| chr_page | output | 6 | 1 KB page index in ROM or RAM |
| chr_ram_we | output | 1 | Write strobe to pattern RAM |
| mirror_h | output | 1 | 1 for horizontal, 0 for vertical nametable arrangement |
| wram_rd_en | output | 1 | Work-RAM read allowed at `cpu_addr` |
| wram_we | output | 1 | Work-RAM write strobe |

## Verification
Every output is a combinational view of stored state, so a corrupted bank value or control byte shows up on `prg_bank` or `chr_page` as soon as an address that uses it is presented, within the same cycle. A bad layout bit is subtler. A wrong program-mode bit still gives the correct answer in slots 1 and 3, and it only shows in slots 0 and 2. A wrong half-swap bit only shows when the two halves hold different values. The bench therefore probes every slot in both modes and puts distinct values in both halves. A wrong RAM/ROM flag can reach pattern ROM as a write, so the write strobe is checked on both page kinds.

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int PRG_BANKS = 32,
  localparam int PW = $clog2(PRG_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  input  logic [13:0]   ppu_addr,
  input  logic          ppu_wr,
  output logic [PW-1:0] prg_bank,
  output logic          chr_is_ram,
  output logic [5:0]    chr_page,
  output logic          chr_ram_we,
  output logic          mirror_h,
  output logic          wram_rd_en,
  output logic          wram_we
);
  localparam logic [PW-1:0] LAST   = PW'(PRG_BANKS - 1);
  localparam logic [PW-1:0] SECOND = PW'(PRG_BANKS - 2);

  logic [7:0] regs [8];
  logic [7:0] ctl;
  logic       ram_en, ram_lock;

  wire hit_bank = cpu_wr && cpu_addr[15:13] == 3'b100;
  wire hit_ctl  = cpu_wr && cpu_addr[15:13] == 3'b101;
  wire hit_wram = cpu_addr[15:13] == 3'b011;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
      ctl      <= '0;
      mirror_h <= 1'b0;
      ram_en   <= 1'b1;
      ram_lock <= 1'b0;
    end else begin
      if (hit_bank && !cpu_addr[0]) ctl <= cpu_wdata;
      if (hit_bank &&  cpu_addr[0]) regs[ctl[2:0]] <= cpu_wdata;
      if (hit_ctl  && !cpu_addr[0]) mirror_h <= cpu_wdata[0];
      if (hit_ctl  &&  cpu_addr[0]) {ram_en, ram_lock} <= cpu_wdata[7:6];
    end
  end

  wire [PW-1:0] b6 = PW'(32'(regs[6]) % 32'(PRG_BANKS));
  wire [PW-1:0] b7 = PW'(32'(regs[7]) % 32'(PRG_BANKS));

  always_comb begin
    case ({ctl[6], cpu_addr[14:13]})
      3'b000:  prg_bank = b6;
      3'b001:  prg_bank = b7;
      3'b010:  prg_bank = SECOND;
      3'b100:  prg_bank = SECOND;
      3'b101:  prg_bank = b7;
      3'b110:  prg_bank = b6;
      default: prg_bank = LAST;
    endcase
  end

  wire [2:0] pg = ppu_addr[12:10] ^ {ctl[7], 2'b00};
  logic [7:0] v;

  always_comb begin
    case (pg)
      3'd0:    v = {regs[0][7:1], 1'b0};
      3'd1:    v = {regs[0][7:1], 1'b1};
      3'd2:    v = {regs[1][7:1], 1'b0};
      3'd3:    v = {regs[1][7:1], 1'b1};
      3'd4:    v = regs[2];
      3'd5:    v = regs[3];
      3'd6:    v = regs[4];
      default: v = regs[5];
    endcase
  end

  assign chr_is_ram = v[6];
  assign chr_page   = v[6] ? {3'b000, v[2:0]} : v[5:0];
  assign chr_ram_we = ppu_wr && !ppu_addr[13] && v[6];
  assign wram_rd_en = hit_wram && ram_en;
  assign wram_we    = cpu_wr && hit_wram && ram_en && !ram_lock;
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int PRG_BANKS = 32,
  localparam int PW = $clog2(PRG_BANKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic [15:0]   cpu_addr,
  input logic [13:0]   ppu_addr,
  input logic          ppu_wr,
  input logic [PW-1:0] prg_bank,
  input logic          chr_is_ram,
  input logic [5:0]    chr_page,
  input logic          chr_ram_we,
  input logic          mirror_h,
  input logic          wram_rd_en,
  input logic          wram_we
);
  a_r2_last_slot_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] == 3'b111 |-> prg_bank == PW'(PRG_BANKS - 1));

  a_r7_ram_page_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    chr_is_ram |-> chr_page[5:3] == 3'b000);

  a_r8_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ram_we |-> chr_is_ram && ppu_wr && !ppu_addr[13]);

  a_r9_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]) |=> $stable(mirror_h));

  a_r10_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> wram_rd_en && cpu_wr);
endmodule

bind bank_xlate bank_xlate_chk #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .prg_bank(prg_bank),
  .chr_is_ram(chr_is_ram), .chr_page(chr_page), .chr_ram_we(chr_ram_we),
  .mirror_h(mirror_h), .wram_rd_en(wram_rd_en), .wram_we(wram_we)
);

// File: tb/sim_bank_xlate.sv
module sim_bank_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int PW = $clog2(NB);

  logic clk = 0, rst_n = 0, cpu_wr = 0, ppu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [13:0] ppu_addr = 0;
  logic [PW-1:0] prg_bank;
  logic chr_is_ram, chr_ram_we, mirror_h, wram_rd_en, wram_we;
  logic [5:0] chr_page;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_xlate #(.PRG_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .prg_bank(prg_bank), .chr_is_ram(chr_is_ram), .chr_page(chr_page),
    .chr_ram_we(chr_ram_we), .mirror_h(mirror_h), .wram_rd_en(wram_rd_en),
    .wram_we(wram_we));

  // {ctl, value6, value7, probe address, expected bank}
  localparam logic [47:0] PRG_VEC [10] = '{
    {8'h00, 8'd3,  8'd5,   16'h8000, 8'd3},
    {8'h00, 8'd3,  8'd5,   16'hA000, 8'd5},
    {8'h00, 8'd3,  8'd5,   16'hC000, 8'd30},
    {8'h00, 8'd3,  8'd5,   16'hE000, 8'd31},
    {8'h40, 8'd3,  8'd5,   16'h8000, 8'd30},
    {8'h40, 8'd3,  8'd5,   16'hA000, 8'd5},
    {8'h40, 8'd3,  8'd5,   16'hC000, 8'd3},
    {8'h40, 8'd3,  8'd5,   16'hE000, 8'd31},
    {8'h00, 8'd37, 8'd5,   16'h8000, 8'd5},
    {8'h40, 8'd3,  8'hFF,  16'hA000, 8'd31}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic set_val(input int idx, input logic [7:0] d, input logic [7:0] keep);
    wr(16'h8000, (keep & 8'hC0) | 8'(idx));
    wr(16'h8001, d);
  endtask

  task automatic chr_at(input logic [13:0] a);
    @(negedge clk);
    ppu_addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mirror", mirror_h, 0);
    cpu_addr = 16'h8000; #1;
    chk("R11 prg bank", prg_bank, 0);
    chr_at(14'h0000);
    chk("R11 chr page", chr_page, 0);
    chk("R11 chr rom", chr_is_ram, 0);
    cpu_addr = 16'h6000; cpu_wr = 1; #1;
    chk("R11 wram rd", wram_rd_en, 1);
    chk("R11 wram we", wram_we, 1);
    @(negedge clk); cpu_wr = 0;

    // R2 R3 R4 table
    foreach (PRG_VEC[i]) begin
      logic [47:0] e;
      e = PRG_VEC[i];
      set_val(6, e[39:32], 8'h00);
      set_val(7, e[31:24], 8'h00);
      wr(16'h8000, e[47:40]);
      cpu_addr = e[23:8]; #1;
      chk($sformatf("R2/R3/R4 vec%0d", i), prg_bank, e[7:0]);
    end

    // R1 R5 layout, normal orientation
    wr(16'h8000, 8'h03); wr(16'h8001, 8'h11);
    wr(16'h9FFE, 8'h02); wr(16'h9FFF, 8'h22);
    set_val(0, 8'h0B, 8'h00);
    set_val(1, 8'h14, 8'h00);
    chr_at(14'h1400); chk("R1 value3 to page5", chr_page, 8'h11);
    chr_at(14'h1000); chk("R1 alias address page4", chr_page, 8'h22);
    chr_at(14'h0000); chk("R5 page0", chr_page, 8'h0A);
    chr_at(14'h0400); chk("R5 page1", chr_page, 8'h0B);
    chr_at(14'h0800); chk("R5 page2", chr_page, 8'h14);
    chr_at(14'h0C00); chk("R5 page3", chr_page, 8'h15);

    // R6 swapped halves
    wr(16'h8000, 8'h80);
    chr_at(14'h1000); chk("R6 page4", chr_page, 8'h0A);
    chr_at(14'h1C00); chk("R6 page7", chr_page, 8'h15);
    chr_at(14'h0000); chk("R6 page0", chr_page, 8'h22);
    chr_at(14'h0400); chk("R6 page1", chr_page, 8'h11);

    // R7 RAM/ROM select
    set_val(5, 8'h4D, 8'h00);
    set_val(4, 8'hAB, 8'h00);
    chr_at(14'h1C00); chk("R7 ram flag", chr_is_ram, 1);
    chk("R7 ram page", chr_page, 5);
    chr_at(14'h1800); chk("R7 rom flag", chr_is_ram, 0);
    chk("R7 rom page mask", chr_page, 8'h2B);

    // R8 pattern writes
    @(negedge clk); ppu_wr = 1; ppu_addr = 14'h1C00; #1;
    chk("R8 ram page write", chr_ram_we, 1);
    ppu_addr = 14'h1800; #1;
    chk("R8 rom page write", chr_ram_we, 0);
    ppu_addr = 14'h3C00; #1;
    chk("R8 above pattern space", chr_ram_we, 0);
    @(negedge clk); ppu_wr = 0;

    // R9 arrangement
    wr(16'hA000, 8'h01); chk("R9 horizontal", mirror_h, 1);
    wr(16'hA001, 8'h80); chk("R9 odd write keeps", mirror_h, 1);
    wr(16'hA000, 8'hFE); chk("R9 vertical", mirror_h, 0);
    wr(16'hBFFE, 8'h01); chk("R9 alias", mirror_h, 1);

    // R10 work RAM gating
    wr(16'hA001, 8'h00);
    @(negedge clk); cpu_addr = 16'h7FFF; cpu_wr = 1; #1;
    chk("R10 disabled rd", wram_rd_en, 0);
    chk("R10 disabled we", wram_we, 0);
    @(negedge clk); cpu_wr = 0;
    wr(16'hA001, 8'hC0);
    @(negedge clk); cpu_addr = 16'h6000; cpu_wr = 1; #1;
    chk("R10 locked rd", wram_rd_en, 1);
    chk("R10 locked we", wram_we, 0);
    @(negedge clk); cpu_wr = 0;
    wr(16'hA001, 8'h80);
    @(negedge clk); cpu_addr = 16'h6123; cpu_wr = 1; #1;
    chk("R10 open we", wram_we, 1);
    @(negedge clk); cpu_wr = 0;
    cpu_addr = 16'h8000; #1;
    chk("R10 rd outside window", wram_rd_en, 0);

    // R12 ignored writes
    wr(16'h8000, 8'h00);
    cpu_addr = 16'h8000; #1;
    begin
      int pb;
      pb = prg_bank;
      wr(16'hC000, 8'hFF); wr(16'hC001, 8'hFF);
      wr(16'hE000, 8'hFF); wr(16'hE001, 8'hFF);
      wr(16'h4000, 8'hFF);
      cpu_addr = 16'h8000; #1;
      chk("R12 prg unchanged", prg_bank, pb);
      chk("R12 mirror unchanged", mirror_h, 1);
      chr_at(14'h0000); chk("R12 chr unchanged", chr_page, 8'h0A);
      cpu_addr = 16'h6000; #1;
      chk("R12 wram enable unchanged", wram_rd_en, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule